// File: doc/BRIEF.md
# Asynchronous SRAM Host Cycle Controller

This block sits between a synchronous request port and an asynchronous 2K x 8 nonvolatile static RAM. It converts each request (address, write data, a write flag) into a bus cycle driven by the controller's own registers, using chip-select, output-enable and write-strobe lines that are all active low. Each part of the cycle is held for a whole number of clock cycles, and every one of those counts is a parameter. The memory's data bus is split into an output byte, an output-enable flag and an input byte. The pad driver that merges them into a bidirectional bus is outside this block.

The memory pulls an open-drain busy line low while it copies its array into nonvolatile storage. The controller passes that line through a synchronizer. It starts no cycle while the synchronized line is low, and it waits a further recovery interval after the line returns high. A request that arrives during this time stays pending and is served later. When an access finishes, the block raises a one-cycle completion pulse. On a read, the byte is returned with that pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `rdy` are 0.
- R2: A read accepted on clock edge k drives `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 from edge k+SETUP_CYC until edge k+SETUP_CYC+STROBE_CYC. The byte on `mem_dq_in` at that last edge appears on `rdata` when `rdy` is 1, after edge k+SETUP_CYC+STROBE_CYC+HOLD_CYC.
- R3: A write accepted on edge k drives `mem_ce_n`=0 and `mem_we_n`=0 over the same window as a read, with `mem_oe_n` held at 1 throughout. `mem_dq_oe`=1 and `mem_dq_out`=the request's byte from edge k until the edge that raises `rdy`, so the data is set up before the write strobe rises and held after it.
- R4: `mem_addr` changes only while `mem_ce_n` and `mem_we_n` are both 1. It stays constant for as long as either strobe is 0.
- R5: A request is accepted only when the busy line has been seen high through a SYNC_STAGES-flop synchronizer, and has then stayed high for RECOVER_CYC further cycles. With the defaults, a request already pending when the line is released gets `rdy` at the falling clock edge 42 cycles after the release.
- R6: While the memory is busy, a pending request keeps `rdy` at 0 and all strobes at 1. It is not dropped: it is performed once R5 allows, using the address, data and write flag present at acceptance.
- R7: The busy line falling during an access in progress does not shorten or abort that access.
- R8: `rdy` is high for exactly one cycle per access. No new request is accepted on the edge that ends the cycle in which `rdy` is high.
- R9: If the next request is presented in the cycle where `rdy` is high, it is accepted one edge later. An idle request completes SETUP_CYC+STROBE_CYC+HOLD_CYC+1 falling edges after it is raised, and a back-to-back request one edge later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request pending; held until `rdy` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read byte, valid with `rdy` |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enables the data-bus drivers |
| mem_dq_in | input | DATA_W | Byte returned by the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_busy_n | input | 1 | Store-busy line, low while busy |

## Verification
Every output of this block comes from a register. A wrong phase counter or state therefore shows up in the very next clock. It appears as a strobe that falls or rises one edge off, a data enable that drops before the write strobe rises, or a completion pulse on the wrong edge. The per-clock comparison against a model built on access age catches this. A fault in the busy path does not show until the line is released. It then appears as the pending request being served too early or too late, which the latency check after release measures to the exact cycle.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SETUP     = 3'd1,
    ST_STROBE    = 3'd2,
    ST_HOLD      = 3'd3,
    ST_WAIT_BUSY = 3'd4
  } cyc_state_t;
endpackage

// File: rtl/sram_busy_sync.sv
module sram_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_n_async,
  output logic busy_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
    end else begin
      chain[0] <= busy_n_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign busy_n_sync = chain[STAGES-1];
endmodule

// File: rtl/sram_recovery_timer.sv
module sram_recovery_timer #(
  parameter int RECOVER_CYC = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_n_sync,
  output logic access_ok
);
  localparam int CW = (RECOVER_CYC < 1) ? 1 : $clog2(RECOVER_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(RECOVER_CYC);

  logic [CW-1:0] remain;

  // Reload while busy; count down once the line is back high.
  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (!busy_n_sync)  remain <= RELOAD;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign access_ok = busy_n_sync && (remain == '0);
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_cyc_pkg::*;
#(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          access_ok,
  input  logic [DW-1:0] dq_in,
  output logic          rdy,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output cyc_state_t    state
);
  localparam int MAX_SS = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAXC   = (MAX_SS > HOLD_CYC) ? MAX_SS : HOLD_CYC;
  localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STROBE_LD = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          can_start;
  logic          cnt_done;

  // The cycle that carries rdy never accepts, so a held request is not replayed.
  assign can_start = req && access_ok && !rdy;
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      rdy      <= 1'b0;
      rdata    <= '0;
      mem_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
    end else begin
      rdy <= 1'b0;
      unique case (state)
        ST_IDLE, ST_WAIT_BUSY: begin
          if (can_start) begin
            state    <= ST_SETUP;
            cnt      <= SETUP_LD;
            wr_q     <= req_write;
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
            dq_oe    <= req_write;
          end else begin
            state <= access_ok ? ST_IDLE : ST_WAIT_BUSY;
          end
        end
        ST_SETUP: begin
          if (cnt_done) begin
            state <= ST_STROBE;
            cnt   <= STROBE_LD;
            ce_n  <= 1'b0;
            we_n  <= !wr_q;
            oe_n  <= wr_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt_done) begin
            state <= ST_HOLD;
            cnt   <= HOLD_LD;
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            if (!wr_q) rdata <= dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_done) begin
            state <= ST_IDLE;
            dq_oe <= 1'b0;
            rdy   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int RECOVER_CYC = 35,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic              mem_busy_n
);
  logic       busy_n_sync;
  logic       access_ok;
  cyc_state_t fsm_state;

  sram_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .busy_n_async (mem_busy_n),
    .busy_n_sync  (busy_n_sync)
  );

  sram_recovery_timer #(.RECOVER_CYC(RECOVER_CYC)) u_recover (
    .clk         (clk),
    .rst         (rst),
    .busy_n_sync (busy_n_sync),
    .access_ok   (access_ok)
  );

  sram_cycle_fsm #(
    .AW         (ADDR_W),
    .DW         (DATA_W),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .access_ok (access_ok),
    .dq_in     (mem_dq_in),
    .rdy       (rdy),
    .rdata     (rdata),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .state     (fsm_state)
  );
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_cyc_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic          rdy,
  input logic          access_ok,
  input logic [AW-1:0] addr,
  input cyc_state_t    st
);
  // R2: output enable only inside a selected, non-writing cycle
  a_r2_oe_only_when_read: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!ce_n && we_n));

  // R3: write strobe is always covered by driven data
  a_r3_we_has_data: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (dq_oe && oe_n));

  // R3: data still driven in the cycle the write strobe rises
  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> dq_oe);

  // R4: address frozen while the chip stays selected
  a_r4_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));

  // R4: address moves only with both strobes high
  a_r4_addr_moves_idle: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr) |-> (ce_n && we_n));

  // R5: entering setup requires the recovery timer to have allowed it
  a_r5_start_needs_ok: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETUP && $past(st) != ST_SETUP) |-> $past(access_ok));

  // R8: completion pulse lasts one cycle
  a_r8_rdy_single: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_n      (mem_ce_n),
  .oe_n      (mem_oe_n),
  .we_n      (mem_we_n),
  .dq_oe     (mem_dq_oe),
  .rdy       (rdy),
  .access_ok (access_ok),
  .addr      (mem_addr),
  .st        (fsm_state)
);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
  localparam int S = 1, T = 2, H = 1, RC = 35, SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy_n = 1'b1;
  logic        rdy, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [7:0]  rdata, mem_dq_out, mem_dq_in;
  logic [10:0] mem_addr;

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  sram_cycle_ctrl uut (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_busy_n(busy_n)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // Behavioural memory device
  logic [7:0] dev_mem [2048];
  logic [7:0] ref_mem [2048];
  initial for (int i = 0; i < 2048; i++) begin dev_mem[i] = pat(i); ref_mem[i] = pat(i); end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? dev_mem[mem_addr] : 8'hA5;
  always @(negedge clk) if (!mem_ce_n && !mem_we_n) dev_mem[mem_addr] = mem_dq_oe ? mem_dq_out : 8'h00;

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Reference model: access age counted in edges, busy history, recovery count
  int   age = -1, rec = 0;
  bit   m_rdy = 0, m_wr = 0, bs_old, ok_old, rdy_old;
  bit   sq [SYNC];
  logic [10:0] m_addr;
  logic [7:0]  m_wd, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      age = -1; m_rdy = 0; rec = 0;
      for (int i = 0; i < SYNC; i++) sq[i] = 1'b1;
    end else begin
      bs_old  = sq[SYNC-1];
      ok_old  = bs_old && (rec == 0);
      rdy_old = m_rdy;
      if (!bs_old) rec = RC; else if (rec > 0) rec--;
      for (int i = SYNC - 1; i > 0; i--) sq[i] = sq[i-1];
      sq[0] = busy_n;
      m_rdy = 0;
      if (age < 0) begin
        if (req && ok_old && !rdy_old) begin
          age = 0; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
        end
      end else begin
        age++;
        if (age == S + T + H) begin
          m_rdy = 1;
          if (m_wr) ref_mem[m_addr] = m_wd; else m_rdata = ref_mem[m_addr];
          age = -1;
        end
      end
    end
  end

  // Per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      automatic bit strobe = (age >= S) && (age < S + T);
      automatic logic [4:0] exp_v = {!strobe, !(strobe && m_wr), !(strobe && !m_wr),
                                     (age >= 0) && m_wr, m_rdy};
      automatic logic [4:0] act_v = {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rdy};
      chk(cur_tag, act_v == exp_v, 32'(act_v), 32'(exp_v));
      if (age >= 0) chk("R4", mem_addr == m_addr, 32'(mem_addr), 32'(m_addr));
      if (age >= 0 && m_wr) chk("R3", mem_dq_out == m_wd, 32'(mem_dq_out), 32'(m_wd));
      if (m_rdy && !m_wr) chk("R2", rdata == m_rdata, 32'(rdata), 32'(m_rdata));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  task automatic access(input bit w, input logic [10:0] a, input logic [7:0] d, output int lat);
    req = 1'b1; req_write = w; req_addr = a; req_wdata = d; lat = 0;
    do begin @(negedge clk); lat++; end while (!rdy);
    req = 1'b0;
  endtask

  initial begin
    int lat;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rdy} == 5'b11100,
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rdy}), 32'h1C);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rdy} == 5'b11100,
        32'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rdy}), 32'h1C);

    cur_tag = "R2";
    access(1'b0, 11'h000, 8'h00, lat);
    chk("R2", rdata == pat(0), 32'(rdata), 32'(pat(0)));
    chk("R9", lat == S + T + H + 1, 32'(lat), 32'(S + T + H + 1));
    @(negedge clk);
    access(1'b0, 11'h400, 8'h00, lat);
    chk("R2", rdata == pat(1024), 32'(rdata), 32'(pat(1024)));

    cur_tag = "R3";
    @(negedge clk);
    access(1'b1, 11'h123, 8'h5A, lat);
    @(negedge clk);
    access(1'b1, 11'h7FF, 8'hFF, lat);
    @(negedge clk);
    access(1'b0, 11'h123, 8'h00, lat);
    chk("R3", rdata == 8'h5A, 32'(rdata), 32'h5A);
    @(negedge clk);
    access(1'b0, 11'h7FF, 8'h00, lat);
    chk("R3", rdata == 8'hFF, 32'(rdata), 32'hFF);

    cur_tag = "R9";
    access(1'b1, 11'h010, 8'h3C, lat);
    access(1'b0, 11'h010, 8'h00, lat);
    chk("R9", lat == S + T + H + 2, 32'(lat), 32'(S + T + H + 2));
    chk("R8", rdata == 8'h3C, 32'(rdata), 32'h3C);
    @(negedge clk);
    chk("R8", rdy == 1'b0, 32'(rdy), 32'h0);

    cur_tag = "R6";
    busy_n = 1'b0;
    repeat (4) @(negedge clk);
    req = 1'b1; req_write = 1'b0; req_addr = 11'h055; req_wdata = 8'h00;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R6", {rdy, mem_ce_n} == 2'b01, 32'({rdy, mem_ce_n}), 32'h1);
    end
    cur_tag = "R5";
    busy_n = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rdy);
    req = 1'b0;
    chk("R5", lat == SYNC + 1 + RC + S + T + H, 32'(lat), 32'(SYNC + 1 + RC + S + T + H));
    chk("R6", rdata == pat(11'h055), 32'(rdata), 32'(pat(11'h055)));

    cur_tag = "R7";
    @(negedge clk);
    fork
      access(1'b1, 11'h2AA, 8'hC3, lat);
      begin repeat (2) @(negedge clk); busy_n = 1'b0; end
    join
    chk("R7", lat == S + T + H + 1, 32'(lat), 32'(S + T + H + 1));
    cur_tag = "R6";
    @(negedge clk);
    req = 1'b1; req_write = 1'b0; req_addr = 11'h2AA;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R6", {rdy, mem_ce_n} == 2'b01, 32'({rdy, mem_ce_n}), 32'h1);
    end
    busy_n = 1'b1;
    do @(negedge clk); while (!rdy);
    req = 1'b0;
    chk("R7", rdata == 8'hC3, 32'(rdata), 32'hC3);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule